// File: doc/BRIEF.md
# Burst Length Symbol Counter

This block decides how long the receiver remains in data mode after a burst has been acquired. Software programs a 16-bit burst length through a byte-wide register port, one write for each byte. When the preamble detector reports an acquisition, the block enters data mode and counts the data symbols that the demodulator strobes out. When the programmed allowance has been used up, it leaves data mode and emits a one-cycle end-of-burst pulse, so that the receiver can go back to searching for the next burst.

The programmed value is biased by two: a value of V lets V minus 2 data symbols through. Values below three are raised to three, so every burst carries at least one symbol. The length used by a burst is captured when that burst starts, so register writes made during a burst only apply to the next one. Pulling the receiver enable low abandons a burst at once and does not produce an end-of-burst pulse.

Top module: `burst_symbol_counter`

## Requirements
- R1: After reset, `data_mode` and `burst_end` are both low.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data` into the low byte of the length (bits 7:0) when `cfg_wr_sel` is 0, and into the high byte (bits 15:8) when `cfg_wr_sel` is 1.
- R3: For a programmed value V from 3 to 65535, `data_mode` stays high through exactly V-2 accepted `sym_valid` strobes, whatever the gaps between them. It falls on the cycle after the clock edge that samples the last of them.
- R4: A programmed value of 0, 1 or 2 acts as 3, so exactly one data symbol is accepted.
- R5: The value 0xFFFF gives 65533 accepted data symbols.
- R6: `burst_end` is high for exactly one cycle. That cycle is the first cycle in which `data_mode` reads low after a burst ends on its symbol count.
- R7: `acq_found` sampled high while `data_mode` is low and `rx_enable` is high sets `data_mode` on the next cycle and starts a fresh count with the full programmed length.
- R8: `acq_found` has no effect while `data_mode` is high: the running count is neither restarted nor ended.
- R9: A length write made during a burst does not change that burst's length. It applies from the next burst on.
- R10: `rx_enable` sampled low clears `data_mode` on the next cycle without a `burst_end` pulse. While `rx_enable` is low, `acq_found` is ignored.
- R11: `sym_valid` strobes while `data_mode` is low are not counted toward the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enable; low forces acquisition mode |
| cfg_wr_en | input | 1 | Length byte write strobe |
| cfg_wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| cfg_wr_data | input | 8 | Byte to write |
| acq_found | input | 1 | Acquisition/preamble detected pulse |
| sym_valid | input | 1 | One data symbol delivered by the demodulator |
| data_mode | output | 1 | High while the receiver is in data mode |
| burst_end | output | 1 | One-cycle pulse when the symbol allowance runs out |

## Verification
A wrong count state shows up as a `data_mode` edge that comes earlier or later than the V-2 strobe mark. It is visible on the cycle after the last expected symbol, so every burst is checked against that exact edge at one or more lengths. A wrongly captured or clamped limit shows up in the same way, at the end of the first burst that uses it. The mid-burst writes and acquisitions reveal a limit that is not held or a counter that restarts within a single burst. A stale count left over from idle strobes or from an aborted burst shows up as a short next burst.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
   typedef enum logic {
      MODE_ACQ  = 1'b0,
      MODE_DATA = 1'b1
   } bsc_mode_e;

   localparam int BSC_DEF_LEN_W  = 16;
   localparam int BSC_DEF_BYTE_W = 8;
endpackage

// File: rtl/bsc_len_regs.sv
module bsc_len_regs #(
   parameter int LEN_W     = 16,
   parameter int BYTE_W    = 8,
   parameter int MIN_PROG  = 3,
   parameter int OFFSET    = 2,
   parameter int RESET_LEN = 3,
   localparam int NUM_BYTES = LEN_W / BYTE_W,
   localparam int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              capture,
   output logic [LEN_W-1:0]  next_limit,
   output logic [LEN_W-1:0]  limit
);
   localparam logic [LEN_W-1:0] RST_VAL = LEN_W'(RESET_LEN);
   localparam logic [LEN_W-1:0] MIN_VAL = LEN_W'(MIN_PROG);
   localparam logic [LEN_W-1:0] OFS_VAL = LEN_W'(OFFSET);

   logic [BYTE_W-1:0] byte_q [NUM_BYTES];
   logic [LEN_W-1:0]  prog_val;
   logic [LEN_W-1:0]  clamped;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q[g] <= RST_VAL[g*BYTE_W +: BYTE_W];
         end else if (wr_en && (wr_sel == SEL_W'(g))) begin
            byte_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      prog_val = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         prog_val[i*BYTE_W +: BYTE_W] = byte_q[i];
      end
   end

   assign clamped    = (prog_val < MIN_VAL) ? MIN_VAL : prog_val;
   assign next_limit = clamped - OFS_VAL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit <= MIN_VAL - OFS_VAL;
      end else if (capture) begin
         limit <= next_limit;
      end
   end
endmodule

// File: rtl/bsc_sym_count.sv
module bsc_sym_count #(
   parameter int LEN_W      = 16,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             sym_valid,
   input  logic [LEN_W-1:0] load_val,
   input  logic [LEN_W-1:0] limit,
   output logic             last_sym
);
   logic take;
   assign take = active && sym_valid;

   if (COUNT_DOWN) begin : g_down
      logic [LEN_W-1:0] remain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            remain_q <= '0;
         end else if (start) begin
            remain_q <= load_val;
         end else if (take) begin
            remain_q <= remain_q - LEN_W'(1);
         end
      end
      assign last_sym = take && (remain_q == LEN_W'(1));
   end else begin : g_up
      logic [LEN_W-1:0] count_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            count_q <= '0;
         end else if (start) begin
            count_q <= '0;
         end else if (take) begin
            count_q <= count_q + LEN_W'(1);
         end
      end
      assign last_sym = take && ((count_q + LEN_W'(1)) == limit);
   end
endmodule

// File: rtl/burst_symbol_counter.sv
module burst_symbol_counter #(
   parameter int LEN_W      = bsc_pkg::BSC_DEF_LEN_W,
   parameter int BYTE_W     = bsc_pkg::BSC_DEF_BYTE_W,
   parameter int MIN_PROG   = 3,
   parameter int OFFSET     = 2,
   parameter int RESET_LEN  = 3,
   parameter bit COUNT_DOWN = 1'b0,
   localparam int NUM_BYTES = LEN_W / BYTE_W,
   localparam int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              cfg_wr_en,
   input  logic [SEL_W-1:0]  cfg_wr_sel,
   input  logic [BYTE_W-1:0] cfg_wr_data,
   input  logic              acq_found,
   input  logic              sym_valid,
   output logic              data_mode,
   output logic              burst_end
);
   import bsc_pkg::*;

   if (LEN_W % BYTE_W != 0) begin : g_bad_width
      $error("LEN_W must be a whole number of bytes");
   end
   if (MIN_PROG <= OFFSET) begin : g_bad_min
      $error("MIN_PROG must exceed OFFSET so one symbol is always accepted");
   end
   if (MIN_PROG >= (1 << LEN_W) || RESET_LEN >= (1 << LEN_W)) begin : g_bad_range
      $error("length constants do not fit LEN_W");
   end

   bsc_mode_e        mode_q, mode_d;
   logic             start;
   logic             last_sym;
   logic [LEN_W-1:0] next_limit;
   logic [LEN_W-1:0] burst_limit;

   assign start = (mode_q == MODE_ACQ) && acq_found && rx_enable;

   bsc_len_regs #(
      .LEN_W    (LEN_W),
      .BYTE_W   (BYTE_W),
      .MIN_PROG (MIN_PROG),
      .OFFSET   (OFFSET),
      .RESET_LEN(RESET_LEN)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_sel    (cfg_wr_sel),
      .wr_data   (cfg_wr_data),
      .capture   (start),
      .next_limit(next_limit),
      .limit     (burst_limit)
   );

   bsc_sym_count #(
      .LEN_W     (LEN_W),
      .COUNT_DOWN(COUNT_DOWN)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .active   (mode_q == MODE_DATA),
      .sym_valid(sym_valid),
      .load_val (next_limit),
      .limit    (burst_limit),
      .last_sym (last_sym)
   );

   always_comb begin
      mode_d = mode_q;
      if (!rx_enable) begin
         mode_d = MODE_ACQ;
      end else begin
         unique case (mode_q)
            MODE_ACQ:  if (acq_found) mode_d = MODE_DATA;
            MODE_DATA: if (last_sym)  mode_d = MODE_ACQ;
            default:   mode_d = MODE_ACQ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_ACQ;
         burst_end <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         burst_end <= rx_enable && last_sym;
      end
   end

   assign data_mode = (mode_q == MODE_DATA);
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
   parameter int LEN_W    = 16,
   parameter int MIN_PROG = 3,
   parameter int OFFSET   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_enable,
   input logic             acq_found,
   input logic             sym_valid,
   input logic             data_mode,
   input logic             burst_end,
   input logic [LEN_W-1:0] limit
);
   localparam logic [LEN_W-1:0] LIM_MIN = LEN_W'(MIN_PROG - OFFSET);
   localparam logic [LEN_W-1:0] LIM_MAX = {LEN_W{1'b1}} - LEN_W'(OFFSET);

   AST_END_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |-> !data_mode); // R6
   AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |=> !burst_end); // R6
   AST_END_AFTER_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |-> $past(data_mode && sym_valid && rx_enable)); // R3
   AST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_mode && acq_found && rx_enable) |=> data_mode); // R7
   AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> (!data_mode && !burst_end)); // R10
   AST_HOLD_NO_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
      (data_mode && !sym_valid && rx_enable) |=> data_mode); // R8
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_mode && !acq_found) |=> (!data_mode && !burst_end)); // R11
   AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (limit >= LIM_MIN) && (limit <= LIM_MAX)); // R4
endmodule

bind burst_symbol_counter bsc_checker #(
   .LEN_W   (LEN_W),
   .MIN_PROG(MIN_PROG),
   .OFFSET  (OFFSET)
) u_bsc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_enable(rx_enable),
   .acq_found(acq_found),
   .sym_valid(sym_valid),
   .data_mode(data_mode),
   .burst_end(burst_end),
   .limit    (burst_limit)
);

// File: tb/tb_burst_symbol_counter.sv
module tb_burst_symbol_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_enable = 1'b1;
   logic       cfg_wr_en = 1'b0;
   logic [0:0] cfg_wr_sel = 1'b0;
   logic [7:0] cfg_wr_data = 8'h00;
   logic       acq_found = 1'b0;
   logic       sym_valid = 1'b0;
   logic       data_mode;
   logic       burst_end;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   burst_symbol_counter dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_enable  (rx_enable),
      .cfg_wr_en  (cfg_wr_en),
      .cfg_wr_sel (cfg_wr_sel),
      .cfg_wr_data(cfg_wr_data),
      .acq_found  (acq_found),
      .sym_valid  (sym_valid),
      .data_mode  (data_mode),
      .burst_end  (burst_end)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_len(input logic [15:0] val);
      cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = val[7:0];
      step();
      cfg_wr_sel = 1'b1; cfg_wr_data = val[15:8];
      step();
      cfg_wr_en = 1'b0;
   endtask

   task automatic enter_burst(input string req);
      acq_found = 1'b1;
      step();
      acq_found = 1'b0;
      check(req, "data_mode after acquisition", int'(data_mode), 1);
   endtask

   // act: 0 none, 1 acquisition pulse at symbol k, 2 length write (value 3) at symbol k
   task automatic run_syms(input string req, input int n, input int gap, input int act, input int k);
      int bad_mid = 0;
      for (int i = 1; i <= n; i++) begin
         sym_valid = 1'b1;
         if (i == k && act == 1) acq_found = 1'b1;
         if (i == k && act == 2) begin
            cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 8'h03;
         end
         step();
         sym_valid = 1'b0; acq_found = 1'b0;
         if (i == k && act == 2) begin
            cfg_wr_sel = 1'b1; cfg_wr_data = 8'h00;
            step();
            cfg_wr_en = 1'b0;
            if (!data_mode || burst_end) bad_mid++;
         end
         if (i < n) begin
            if (!data_mode || burst_end) bad_mid++;
            for (int j = 0; j < gap; j++) begin
               step();
               if (!data_mode || burst_end) bad_mid++;
            end
         end
      end
      check(req, "early exit count", bad_mid, 0);
      check(req, "data_mode after last symbol", int'(data_mode), 0);
      check(req, "burst_end with mode drop", int'(burst_end), 1);
      step();
      check(req, "burst_end pulse width", int'(burst_end), 0);
   endtask

   task automatic t_reset();
      check("R1", "data_mode at reset", int'(data_mode), 0);
      check("R1", "burst_end at reset", int'(burst_end), 0);
   endtask

   task automatic t_basic();
      write_len(16'd10);
      enter_burst("R7");
      run_syms("R3", 8, 0, 0, 0);
      enter_burst("R7");
      run_syms("R3", 8, 3, 0, 0);
   endtask

   task automatic t_high_byte();
      write_len(16'h0105);
      enter_burst("R2");
      run_syms("R2", 259, 0, 0, 0);
   endtask

   task automatic t_clamp();
      for (int v = 0; v < 4; v++) begin
         write_len(16'(v));
         enter_burst("R4");
         run_syms("R4", 1, 0, 0, 0);
      end
   endtask

   task automatic t_max();
      write_len(16'hFFFF);
      enter_burst("R5");
      run_syms("R5", 65533, 0, 0, 0);
   endtask

   task automatic t_acq_mid();
      write_len(16'd8);
      enter_burst("R8");
      run_syms("R8", 6, 1, 1, 3);
   endtask

   task automatic t_write_mid();
      write_len(16'd9);
      enter_burst("R9");
      run_syms("R9", 7, 0, 2, 2);
      enter_burst("R9");
      run_syms("R9", 1, 0, 0, 0);
   endtask

   task automatic t_disable();
      int ends = 0;
      write_len(16'd12);
      enter_burst("R10");
      for (int i = 0; i < 4; i++) begin
         sym_valid = 1'b1; step(); sym_valid = 1'b0;
      end
      rx_enable = 1'b0;
      step();
      check("R10", "data_mode after disable", int'(data_mode), 0);
      check("R10", "no burst_end on abort", int'(burst_end), 0);
      acq_found = 1'b1;
      step();
      acq_found = 1'b0;
      if (burst_end) ends++;
      check("R10", "acq ignored while disabled", int'(data_mode), 0);
      step();
      check("R10", "no burst_end while disabled", ends + int'(burst_end), 0);
      rx_enable = 1'b1;
      step();
      enter_burst("R10");
      run_syms("R10", 10, 0, 0, 0);
   endtask

   task automatic t_idle_syms();
      write_len(16'd7);
      for (int i = 0; i < 6; i++) begin
         sym_valid = 1'b1; step();
      end
      sym_valid = 1'b0;
      check("R11", "idle strobes keep acquisition", int'(data_mode), 0);
      enter_burst("R11");
      run_syms("R11", 5, 0, 0, 0);
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic();
      t_high_byte();
      t_clamp();
      t_acq_mid();
      t_write_mid();
      t_disable();
      t_idle_syms();
      t_max();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule